// File: doc/BRIEF.md
# ADC Conversion Controller

This block is the host-side master for a three-wire serial ADC. It drives the convert-start line and the serial clock, and it samples the converter's serial data line. The serial clock comes from the system clock. Its high and low phases each last a whole number of system clocks, and the integrator picks those counts so that the serial clock stays at or below about 24 MHz. Every conversion frame is 16 serial clock cycles long. The controller keeps the ten data bits of the frame and drops the three leading zeros, the two sub-bits and the trailing bit. It presents the result as a 16-bit word with a one-cycle strobe, zero-extended for a unipolar converter and sign-extended for a bipolar one.

Commands arrive as a one-cycle code. There are five of them: single conversion, continuous conversion, partial power-down, full power-down and wake-up. The converter takes power-down requests only through frame shape, not through any register. Convert-start is pulled low for a shortened 8-cycle frame and released at a precise point. Doing this twice gives the deeper state. A command that arrives while a frame is running waits in a one-entry slot. The first full conversion after reset is an initialization frame, so its result is thrown away.

Top module: `adc_conv_ctrl`

## Requirements
- R1: While reset is held and just after it, `adc_cnvst` is 1, `adc_sclk` is 0, `res_valid` is 0 and `res_data` is 0.
- R2: A frame starts by driving `adc_cnvst` low while `adc_sclk` is low. The serial clock idles low, so each cycle is a rising edge followed by a falling edge. A single conversion (op code 1) runs 16 cycles and raises `adc_cnvst` at the 16th falling edge. `adc_cnvst` only ever changes while `adc_sclk` is low.
- R3: Every high phase of `adc_sclk` lasts at least `HI_CYC` system clocks. Every low phase lasts at least `LO_CYC` system clocks. This includes the time from the fall of `adc_cnvst` to the first rising edge.
- R4: The converter launches frame bit k on rising edge k, for k from 1 to 16. Bits 4 through 13 are D9 down to D0, MSB first. The controller samples bit k at the falling edge that follows rising edge k when `SAMPLE_FALL`=1, and at rising edge k+1 when `SAMPLE_FALL`=0. Bits 1–3 and 14–16 never reach the result.
- R5: `res_valid` is a one-cycle pulse that follows each reported frame. When `BIPOLAR`=0, `res_data` holds the code in bits 9:0 and zeros in bits 15:10. When `BIPOLAR`=1, bits 15:10 copy bit 9. `res_data` keeps its value until the next result.
- R6: After reset, the first completed 16-cycle single or continuous frame produces no `res_valid`. Every later one produces exactly one.
- R7: Continuous conversion (op code 2) raises `adc_cnvst` at the 14th falling edge and finishes 16 cycles. It then starts the next frame after `HI_CYC` clocks with `adc_cnvst` high. This repeats until a command is pending.
- R8: Partial power-down (op code 3) runs 8 cycles and raises `adc_cnvst` at the 8th falling edge. After that, `adc_sclk` stays low and `adc_cnvst` stays high.
- R9: Full power-down (op code 4) runs two such 8-cycle frames, `HI_CYC` clocks apart. After that, the serial lines stay static.
- R10: Wake-up (op code 5) is carried out only from a power-down state. It runs a 16-cycle frame with `adc_cnvst` low, produces no result, and returns the block to the active state without a new initialization frame.
- R11: Some commands are dropped with no frame. These are: codes 0, 6 and 7; wake-up while active; and any command other than wake-up while powered down.
- R12: A command received while a frame or gap is in progress is held until the current frame (and, for full power-down, its second frame) completes. Only the most recent such command is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code: 1 single, 2 continuous, 3 partial power-down, 4 full power-down, 5 wake-up |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cnvst | output | 1 | Convert-start line to the converter, idles high |
| adc_sclk | output | 1 | Serial clock to the converter, idles low |
| res_data | output | 16 | Last result, extended to 16 bits |
| res_valid | output | 1 | One-cycle strobe for a new result |

## Verification
The bench builds the block with `HI_CYC`=2 and `LO_CYC`=3. Because the two counts differ, a swap between the high-phase and low-phase counts shows up as a timing violation. `BIPOLAR`=1 lets the test codes 0x200 and 0x1FF exercise the sign extension. `SAMPLE_FALL`=0 selects next-rising-edge sampling, which is the mode where an off-by-one in the bit window would shift every result. The converter model drives the sub-bits as ones, so any leak of them into the result changes the value.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_SINGLE = 3'd1,
        OP_CONT   = 3'd2,
        OP_PPD    = 3'd3,
        OP_FPD    = 3'd4,
        OP_WAKE   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FRAME = 2'd1,
        SQ_GAP   = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        PW_ON   = 2'd0,
        PW_PART = 2'd1,
        PW_FULL = 2'd2
    } pwr_e;

    localparam int EDGE_W     = 5;
    localparam int FULL_EDGES = 16;
    localparam int PD_EDGES   = 8;
    localparam int CONT_RAISE = 14;
    localparam int FIRST_DBIT = 4;
    localparam int LAST_DBIT  = 13;
    localparam int CODE_W     = LAST_DBIT - FIRST_DBIT + 1;
    localparam int WORD_W     = 16;

endpackage

// File: rtl/adcc_cmd_slot.sv
module adcc_cmd_slot
    import adcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [2:0] in_op,
    input  logic       take,
    output logic       pend_vld,
    output op_e        pend_op
);

    typedef struct packed {
        logic vld;
        op_e  op;
    } slot_t;

    slot_t s_d, s_q;
    logic  legal;

    always_comb begin
        case (in_op)
            3'd1, 3'd2, 3'd3, 3'd4, 3'd5: legal = 1'b1;
            default:                      legal = 1'b0;
        endcase
        s_d = s_q;
        if (take) begin
            s_d.vld = 1'b0;
        end
        if (in_valid && legal) begin
            s_d.vld = 1'b1;
            s_d.op  = op_e'(in_op);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{vld: 1'b0, op: OP_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_vld = s_q.vld;
    assign pend_op  = s_q.op;

endmodule

// File: rtl/adcc_sclk_gen.sv
module adcc_sclk_gen #(
    parameter int HI_CYC = 2,
    parameter int LO_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int MAXC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } gen_t;

    gen_t g_d, g_q;

    always_comb begin
        g_d    = g_q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        if (!run_i) begin
            g_d = '0;
        end else if (!g_q.lvl) begin
            if (g_q.cnt == CW'(LO_CYC - 1)) begin
                g_d.lvl = 1'b1;
                g_d.cnt = '0;
                rise_o  = 1'b1;
            end else begin
                g_d.cnt = g_q.cnt + CW'(1);
            end
        end else begin
            if (g_q.cnt == CW'(HI_CYC - 1)) begin
                g_d.lvl = 1'b0;
                g_d.cnt = '0;
                fall_o  = 1'b1;
            end else begin
                g_d.cnt = g_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign sclk_o = g_q.lvl;

endmodule

// File: rtl/adcc_capture.sv
module adcc_capture #(
    parameter int BIPOLAR = 0,
    parameter int RES_W   = 10,
    parameter int OUT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             shift_i,
    input  logic             bit_i,
    input  logic             publish_i,
    output logic [OUT_W-1:0] data_o,
    output logic             valid_o
);

    localparam int EXT_W = OUT_W - RES_W;

    typedef struct packed {
        logic [RES_W-1:0] sh;
        logic [OUT_W-1:0] res;
        logic             vld;
    } cap_t;

    cap_t             c_d, c_q;
    logic [OUT_W-1:0] wide;

    generate
        if (BIPOLAR != 0) begin : g_signed
            assign wide = {{EXT_W{c_q.sh[RES_W-1]}}, c_q.sh};
        end else begin : g_unsigned
            assign wide = {{EXT_W{1'b0}}, c_q.sh};
        end
    endgenerate

    always_comb begin
        c_d     = c_q;
        c_d.vld = 1'b0;
        if (clear_i) begin
            c_d.sh = '0;
        end else if (shift_i) begin
            c_d.sh = {c_q.sh[RES_W-2:0], bit_i};
        end
        if (publish_i) begin
            c_d.res = wide;
            c_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign data_o  = c_q.res;
    assign valid_o = c_q.vld;

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adcc_pkg::*;
#(
    parameter int HI_CYC      = 2,
    parameter int LO_CYC      = 2,
    parameter int BIPOLAR     = 0,
    parameter int SAMPLE_FALL = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic        adc_dout,
    output logic        adc_cnvst,
    output logic        adc_sclk,
    output logic [15:0] res_data,
    output logic        res_valid
);

    localparam int GW = (HI_CYC < 2) ? 1 : $clog2(HI_CYC);
    localparam logic [GW-1:0]     GAP_LAST  = GW'(HI_CYC - 1);
    localparam logic [EDGE_W-1:0] E_FULL    = EDGE_W'(FULL_EDGES);
    localparam logic [EDGE_W-1:0] E_PD      = EDGE_W'(PD_EDGES);
    localparam logic [EDGE_W-1:0] E_RAISE   = EDGE_W'(CONT_RAISE);
    localparam logic [EDGE_W-1:0] E_FIRST   = EDGE_W'(FIRST_DBIT);
    localparam logic [EDGE_W-1:0] E_LAST    = EDGE_W'(LAST_DBIT);
    localparam logic [EDGE_W-1:0] K_OFFSET  = (SAMPLE_FALL != 0) ? EDGE_W'(1) : EDGE_W'(0);

    typedef struct packed {
        seq_e              st;
        pwr_e              pwr;
        op_e               kind;
        logic              second;
        logic              cnv;
        logic              run;
        logic              inited;
        logic [EDGE_W-1:0] edges;
        logic [GW-1:0]     gap;
    } seq_t;

    seq_t              q_d, q_q;
    logic              pend_vld;
    op_e               pend_op;
    logic              take, start, publish, accept, frame_done;
    logic              clear_sh, shift_en, samp_stb;
    logic              rise_stb, fall_stb;
    op_e               start_op;
    logic [EDGE_W-1:0] n_edge, k_bit;

    adcc_cmd_slot u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (cmd_valid),
        .in_op    (cmd_op),
        .take     (take),
        .pend_vld (pend_vld),
        .pend_op  (pend_op)
    );

    adcc_sclk_gen #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q_q.run),
        .sclk_o (adc_sclk),
        .rise_o (rise_stb),
        .fall_o (fall_stb)
    );

    adcc_capture #(.BIPOLAR(BIPOLAR), .RES_W(CODE_W), .OUT_W(WORD_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_sh),
        .shift_i   (shift_en),
        .bit_i     (adc_dout),
        .publish_i (publish),
        .data_o    (res_data),
        .valid_o   (res_valid)
    );

    // bit index seen at this sampling strobe: last launched bit on a rise,
    // the bit of the current cycle on a fall
    assign samp_stb = (SAMPLE_FALL != 0) ? fall_stb : rise_stb;
    assign k_bit    = q_q.edges + K_OFFSET;
    assign shift_en = (q_q.st == SQ_FRAME) && samp_stb &&
                      (k_bit >= E_FIRST) && (k_bit <= E_LAST);

    always_comb begin
        q_d        = q_q;
        take       = 1'b0;
        start      = 1'b0;
        start_op   = OP_NONE;
        publish    = 1'b0;
        frame_done = 1'b0;
        clear_sh   = 1'b0;
        n_edge     = q_q.edges + EDGE_W'(1);
        accept     = pend_vld && ((q_q.pwr == PW_ON) ? (pend_op != OP_WAKE)
                                                     : (pend_op == OP_WAKE));
        case (q_q.st)
            SQ_IDLE: begin
                if (pend_vld) begin
                    take = 1'b1;
                    if (accept) begin
                        start    = 1'b1;
                        start_op = pend_op;
                    end
                end
            end
            SQ_FRAME: begin
                if (fall_stb) begin
                    q_d.edges = n_edge;
                    case (q_q.kind)
                        OP_CONT: begin
                            if (n_edge == E_RAISE) begin
                                q_d.cnv = 1'b1;
                            end
                            frame_done = (n_edge == E_FULL);
                        end
                        OP_PPD, OP_FPD: frame_done = (n_edge == E_PD);
                        default:        frame_done = (n_edge == E_FULL);
                    endcase
                    if (frame_done) begin
                        q_d.cnv = 1'b1;
                        q_d.run = 1'b0;
                        q_d.st  = SQ_GAP;
                        q_d.gap = '0;
                        case (q_q.kind)
                            OP_SINGLE, OP_CONT: begin
                                if (q_q.inited) begin
                                    publish = 1'b1;
                                end else begin
                                    q_d.inited = 1'b1;
                                end
                            end
                            OP_WAKE: q_d.pwr = PW_ON;
                            OP_PPD:  q_d.pwr = PW_PART;
                            OP_FPD: begin
                                q_d.pwr    = q_q.second ? PW_FULL : PW_PART;
                                q_d.second = ~q_q.second;
                            end
                            default: q_d.pwr = q_q.pwr;
                        endcase
                    end
                end
            end
            SQ_GAP: begin
                if (q_q.gap != GAP_LAST) begin
                    q_d.gap = q_q.gap + GW'(1);
                end else if ((q_q.kind == OP_FPD) && q_q.second) begin
                    start    = 1'b1;
                    start_op = OP_FPD;
                end else if (pend_vld) begin
                    take = 1'b1;
                    if (accept) begin
                        start    = 1'b1;
                        start_op = pend_op;
                    end else begin
                        q_d.st = SQ_IDLE;
                    end
                end else if (q_q.kind == OP_CONT) begin
                    start    = 1'b1;
                    start_op = OP_CONT;
                end else begin
                    q_d.st = SQ_IDLE;
                end
            end
            default: q_d.st = SQ_IDLE;
        endcase
        if (start) begin
            q_d.st    = SQ_FRAME;
            q_d.kind  = start_op;
            q_d.cnv   = 1'b0;
            q_d.run   = 1'b1;
            q_d.edges = '0;
            clear_sh  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: SQ_IDLE, pwr: PW_ON, kind: OP_NONE, second: 1'b0,
                     cnv: 1'b1, run: 1'b0, inited: 1'b0, edges: '0, gap: '0};
        end else begin
            q_q <= q_d;
        end
    end

    assign adc_cnvst = q_q.cnv;

endmodule

// File: rtl/adcc_checker.sv
module adcc_checker #(
    parameter int HI_CYC  = 2,
    parameter int LO_CYC  = 2,
    parameter int BIPOLAR = 0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        adc_cnvst,
    input logic        adc_sclk,
    input logic [15:0] res_data,
    input logic        res_valid
);

    logic [7:0] hi_len, lo_len, rise_cnt;
    logic       prev_cnv, prev_sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len    <= '0;
            lo_len    <= '0;
            rise_cnt  <= '0;
            prev_cnv  <= 1'b1;
            prev_sclk <= 1'b0;
        end else begin
            prev_cnv  <= adc_cnvst;
            prev_sclk <= adc_sclk;
            if (adc_sclk) begin
                hi_len <= (hi_len == 8'hFF) ? hi_len : hi_len + 8'd1;
                lo_len <= '0;
            end else begin
                lo_len <= (lo_len == 8'hFF) ? lo_len : lo_len + 8'd1;
                hi_len <= '0;
            end
            if (prev_cnv && !adc_cnvst) begin
                rise_cnt <= '0;
            end else if (!prev_sclk && adc_sclk) begin
                rise_cnt <= (rise_cnt == 8'hFF) ? rise_cnt : rise_cnt + 8'd1;
            end
        end
    end

    assert_sclk_high_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_sclk) |-> (hi_len >= 8'(HI_CYC)));

    assert_sclk_low_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_sclk) |-> (lo_len >= 8'(LO_CYC)));

    assert_start_sclk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cnvst) |-> !adc_sclk);

    assert_raise_sclk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cnvst) |-> !adc_sclk);

    // R7/R8: release only at the 8th edge or within the 14th..16th
    assert_raise_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cnvst) |-> ((rise_cnt == 8'd8) ||
                              ((rise_cnt >= 8'd14) && (rise_cnt <= 8'd16))));

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_extension_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((BIPOLAR != 0) ? (res_data[15:10] == {6{res_data[9]}})
                                      : (res_data[15:10] == 6'd0)));

endmodule

bind adc_conv_ctrl adcc_checker #(
    .HI_CYC  (HI_CYC),
    .LO_CYC  (LO_CYC),
    .BIPOLAR (BIPOLAR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_cnvst (adc_cnvst),
    .adc_sclk  (adc_sclk),
    .res_data  (res_data),
    .res_valid (res_valid)
);

// File: tb/tb_adc_conv_ctrl.sv
`timescale 1ns/1ps
module tb_adc_conv_ctrl;

    localparam int HI = 2;
    localparam int LO = 3;
    localparam int BIP = 1;
    localparam int SFALL = 0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic        adc_dout = 1'b0;
    logic        adc_cnvst, adc_sclk, res_valid;
    logic [15:0] res_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // converter model state
    int falls = 0, rises = 0, pd_lvl = 0, toggles = 0;
    int results_exp = 0, results_got = 0;
    int hi_run = 0, lo_run = 0;
    bit init_seen = 1'b0;
    logic [9:0]  cur_code = '0;
    logic [15:0] word = '0;
    logic [15:0] exp_m;
    logic [15:0] expq[$];
    logic        prev_s = 1'b0;

    always #2.5 clk = ~clk;

    adc_conv_ctrl #(.HI_CYC(HI), .LO_CYC(LO), .BIPOLAR(BIP), .SAMPLE_FALL(SFALL)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .adc_dout  (adc_dout),
        .adc_cnvst (adc_cnvst),
        .adc_sclk  (adc_sclk),
        .res_data  (res_data),
        .res_valid (res_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] code_of(input int i);
        case (i % 8)
            0: return 10'h3FF;
            1: return 10'h000;
            2: return 10'h200;
            3: return 10'h1FF;
            4: return 10'h155;
            5: return 10'h2AA;
            6: return 10'h001;
            default: return 10'h3FE;
        endcase
    endfunction

    // converter model: frame word is 000, code, sub-bits 11, trailing 0
    always @(negedge adc_cnvst) if (rst_n) begin
        check(adc_sclk == 1'b0, "R2", "sclk level at frame start", adc_sclk, 0);
        cur_code = code_of(falls);
        word = {3'b000, cur_code, 2'b11, 1'b0};
        falls++;
        rises = 0;
        adc_dout = 1'b0;
    end

    always @(posedge adc_sclk) if (rst_n) begin
        rises++;
        toggles++;
        if (rises == 16) begin
            if (pd_lvl > 0) begin
                pd_lvl = 0;
            end else if (!init_seen) begin
                init_seen = 1'b1;
            end else begin
                expq.push_back((BIP != 0) ? {{6{cur_code[9]}}, cur_code} : {6'd0, cur_code});
                results_exp++;
            end
        end
        #1;
        adc_dout = (rises <= 16) ? word[16 - rises] : 1'b0;
    end

    always @(posedge adc_cnvst) if (rst_n) begin
        check((rises == 8) || ((rises >= 14) && (rises <= 16)), "R7",
              "convert-start release edge", rises, 16);
        if ((rises >= 4) && (rises <= 13)) pd_lvl++;
    end

    // monitor: scoreboard and phase timing
    always @(negedge clk) if (rst_n) begin
        if (res_valid) begin
            results_got++;
            if (expq.size() == 0) begin
                check(1'b0, "R6", "unexpected result", res_data, 0);
            end else begin
                exp_m = expq.pop_front();
                check(res_data == exp_m, "R4", "result value", res_data, exp_m);
                check(res_data[15:10] == ((BIP != 0) ? {6{res_data[9]}} : 6'd0), "R5",
                      "upper bits", res_data[15:10], res_data[9] ? 6'h3F : 6'h0);
            end
        end
        if (prev_s && !adc_sclk) check(hi_run >= HI, "R3", "high phase", hi_run, HI);
        if (!prev_s && adc_sclk) check(lo_run >= LO, "R3", "low phase", lo_run, LO);
        if (adc_sclk) begin hi_run++; lo_run = 0; end
        else begin lo_run++; hi_run = 0; end
        prev_s = adc_sclk;
    end

    task automatic send(input logic [2:0] op);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = 3'd0;
    endtask

    task automatic quiet();
        int q = 0;
        while (q < 40) begin
            @(negedge clk);
            if (adc_cnvst && !adc_sclk) q++;
            else q = 0;
        end
    endtask

    initial begin
        int f0, r0, t0;
        repeat (4) @(negedge clk);
        check(adc_cnvst == 1'b1, "R1", "cnvst in reset", adc_cnvst, 1);
        check(adc_sclk == 1'b0, "R1", "sclk in reset", adc_sclk, 0);
        check(res_valid == 1'b0, "R1", "valid in reset", res_valid, 0);
        check(res_data == 16'd0, "R1", "data in reset", res_data, 0);
        rst_n = 1'b1;

        send(3'd1); quiet();
        check(results_got == 0, "R6", "init frame discarded", results_got, 0);
        check(falls == 1, "R2", "single frame count", falls, 1);

        repeat (3) begin send(3'd1); quiet(); end
        check(results_got == 3, "R2", "single results", results_got, 3);

        f0 = falls; r0 = results_got;
        send(3'd2);
        wait (results_got >= 8);
        send(3'd1); quiet();
        check((falls - f0) == (results_got - r0), "R7", "continuous frames vs results",
              falls - f0, results_got - r0);
        check(falls - f0 >= 6, "R7", "continuous run length", falls - f0, 6);

        f0 = falls;
        send(3'd1);
        @(negedge adc_cnvst);
        send(3'd3);
        send(3'd1);
        quiet();
        check(falls == f0 + 2, "R12", "latest pending wins", falls, f0 + 2);
        check(pd_lvl == 0, "R12", "overwritten power-down not run", pd_lvl, 0);

        f0 = falls;
        send(3'd7); send(3'd0); send(3'd6);
        repeat (100) @(negedge clk);
        check(falls == f0, "R11", "undefined codes dropped", falls, f0);
        send(3'd5);
        repeat (100) @(negedge clk);
        check(falls == f0, "R11", "wake while active dropped", falls, f0);

        send(3'd3); quiet();
        check(pd_lvl == 1, "R8", "partial power-down entered", pd_lvl, 1);
        check(falls == f0 + 1, "R8", "one short frame", falls, f0 + 1);
        t0 = toggles;
        repeat (200) @(negedge clk);
        check(toggles == t0, "R8", "sclk static", toggles - t0, 0);
        check(adc_cnvst == 1'b1, "R8", "cnvst idles high", adc_cnvst, 1);
        send(3'd1);
        repeat (100) @(negedge clk);
        check(falls == f0 + 1, "R11", "single ignored while down", falls, f0 + 1);

        r0 = results_got;
        send(3'd5); quiet();
        check(pd_lvl == 0, "R10", "wake from partial", pd_lvl, 0);
        check(results_got == r0, "R10", "wake gives no result", results_got, r0);
        send(3'd1); quiet();
        check(results_got == r0 + 1, "R10", "active after wake", results_got, r0 + 1);

        f0 = falls;
        send(3'd4); quiet();
        check(pd_lvl == 2, "R9", "full power-down entered", pd_lvl, 2);
        check(falls == f0 + 2, "R9", "two short frames", falls, f0 + 2);
        t0 = toggles;
        send(3'd2);
        repeat (200) @(negedge clk);
        check(toggles == t0, "R9", "sclk static, continuous ignored", toggles - t0, 0);
        send(3'd5); quiet();
        check(pd_lvl == 0, "R10", "wake from full", pd_lvl, 0);
        r0 = results_got;
        send(3'd1); quiet();
        check(results_got == r0 + 1, "R10", "result after full wake", results_got, r0 + 1);

        check(expq.size() == 0, "R6", "scoreboard drained", expq.size(), 0);
        check(results_got == results_exp, "R5", "result count", results_got, results_exp);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule